// File: doc/BRIEF.md
# Parallel Multi-Codeword Prefix Decoder

This block decodes a 32-bit slice of a canonical prefix-coded bitstream in a single cycle and returns up to eight symbol indices at once. A length detector sits at every bit offset of the slice, and each one guesses the length of a codeword starting there. A chained walk then keeps only the guesses that can be reached from the first bit. It follows one accepted codeword to the next and drops every other offset.

Each decoded codeword becomes a table index with two parts. The codeword length picks a page, and the codeword's distance from the first code of that length is the position inside the page. No table read is needed, so the symbol lookup can happen downstream. The block also reports how many bits it consumed in total. An external barrel shifter uses that number to present the next slice, and the block can take a new slice on every cycle that its consumer is ready.

Top module: `pvd_decoder`

## Requirements
- R1: After reset the block holds `outValid` low, all slot valid flags low, `symCount` 0, `usedBits` 0, and `inReady` high.
- R2: The code is canonical and sent most significant bit first. It has lengths 1 to 8, and the counts of codes per length are 0,1,2,3,4,6,8,8. The first code values per length are 0,0,2,8,22,52,116,248, and codes rise in value within a length. A decoded slot index has the codeword length in bits [11:8] and (codeword value minus first code of that length) in bits [7:0].
- R3: `window[31]` is the earliest stream bit. Slot 0 holds the codeword that starts at `window[31]`, and each later slot holds the codeword that starts right after the previous one. No other offset produces a symbol.
- R4: A codeword that does not lie wholly inside the window is not decoded. The chain stops before it, and its bits are not counted in `usedBits`.
- R5: At most 8 slots are filled. Once slot 7 is filled, decoding stops even if more complete codewords remain in the window.
- R6: `usedBits` equals the sum of the lengths of the codewords decoded from that window.
- R7: `symCount` equals the number of valid slots. The valid slots are contiguous from slot 0, and the index field of every invalid slot reads 0.
- R8: A window is taken on a rising edge where `inValid` and `inReady` are both high. Its results appear with `outValid` high after that same edge. With `outReady` held high, a new window is accepted on every cycle.
- R9: While `outValid` is high and `outReady` is low, all result outputs hold their values, `inReady` is low, and no window is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | A window is offered |
| inReady | output | 1 | A window can be taken this cycle |
| window | input | 32 | Bitstream slice; bit 31 is the earliest bit |
| outValid | output | 1 | Result registers hold a decoded window |
| outReady | input | 1 | Consumer takes the result this cycle |
| symIdx | output | 96 | Eight 12-bit indices; slot s is bits [12s+11:12s] |
| symValid | output | 8 | Per-slot valid flags, bit s for slot s |
| symCount | output | 4 | Number of decoded symbols |
| usedBits | output | 6 | Bits consumed from the window |

## Verification
Every result is due one rising edge after the window is accepted, because the detectors, the chain and the index forming are combinational and feed a single output register. The bench drives on falling edges. It reads the results of a window at the falling edge that follows the accepting rising edge, or at the next falling edge while the stream is held stalled. In the streaming test, each falling edge compares the results of the window offered one cycle earlier, while the next window is already being offered. That test also checks that the indices collected across many realigned windows reproduce the encoded symbol sequence.

// File: rtl/pvd_pkg.sv
package pvd_pkg;

  // Default canonical code: number of codewords for lengths 1..8
  localparam int unsigned DEF_LEN_COUNT [8] = '{0, 1, 2, 3, 4, 6, 8, 8};

  // Strobes from control to datapath
  typedef struct packed {
    logic loadEn;
  } pvdStrobe_t;

endpackage

// File: rtl/pvd_len_detect.sv
module pvd_len_detect #(
  parameter int MAX_LEN = 8,
  parameter int LEN_W = 4,
  parameter int unsigned LEN_COUNT [MAX_LEN] = pvd_pkg::DEF_LEN_COUNT
) (
  input  logic [MAX_LEN-1:0] look,
  output logic [LEN_W-1:0]   len,
  output logic [MAX_LEN-1:0] offset
);

  // Canonical match: the shortest prefix whose value lies in that length's code range
  always_comb begin : lenScan
    int unsigned first;
    int unsigned prevCnt;
    int unsigned val;
    logic found;
    len = '0;
    offset = '0;
    found = 1'b0;
    first = 0;
    prevCnt = 0;
    for (int l = 1; l <= MAX_LEN; l++) begin
      first = (first + prevCnt) << 1;
      val = 32'(look) >> (MAX_LEN - l);
      if (!found && (val >= first) && (val < first + LEN_COUNT[l-1])) begin
        found = 1'b1;
        len = LEN_W'(l);
        offset = MAX_LEN'(val - first);
      end
      prevCnt = LEN_COUNT[l-1];
    end
  end

endmodule

// File: rtl/pvd_ctrl.sv
module pvd_ctrl (
  input  logic clk,
  input  logic rstN,
  input  logic inValid,
  input  logic outReady,
  output logic inReady,
  output logic outValid,
  output pvd_pkg::pvdStrobe_t strobe
);

  logic validQ;
  logic accept;

  assign inReady = !validQ || outReady;
  assign accept = inValid && inReady;
  assign strobe = '{loadEn: accept};
  assign outValid = validQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validQ <= 1'b0;
    end else if (accept) begin
      validQ <= 1'b1;
    end else if (outReady) begin
      validQ <= 1'b0;
    end
  end

  // R8
  accept_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady) |=> outValid);

  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> outValid);

endmodule

// File: rtl/pvd_datapath.sv
module pvd_datapath #(
  parameter int WIN_W = 32,
  parameter int MAX_LEN = 8,
  parameter int SLOTS = 8,
  parameter int LEN_W = 4,
  parameter int POS_W = 6,
  parameter int CNT_W = 4,
  parameter int IDX_W = 12,
  parameter int unsigned LEN_COUNT [MAX_LEN] = pvd_pkg::DEF_LEN_COUNT
) (
  input  logic clk,
  input  logic rstN,
  input  logic [WIN_W-1:0] window,
  input  pvd_pkg::pvdStrobe_t strobe,
  output logic [SLOTS-1:0][IDX_W-1:0] symIdxQ,
  output logic [SLOTS-1:0] symValidQ,
  output logic [CNT_W-1:0] symCountQ,
  output logic [POS_W-1:0] usedBitsQ
);

  localparam int PAD_W = WIN_W + MAX_LEN;

  logic [PAD_W-1:0] padded;
  logic [LEN_W-1:0] posLen [WIN_W];
  logic [MAX_LEN-1:0] posOff [WIN_W];
  logic [WIN_W-1:0] posFit;

  logic [SLOTS-1:0][IDX_W-1:0] nextIdx;
  logic [SLOTS-1:0] nextValid;
  logic [CNT_W-1:0] nextCnt;
  logic [POS_W-1:0] nextUsed;

  // Zero padding past the end so every detector sees a full lookahead
  assign padded = {window, MAX_LEN'(0)};

  // One speculative length detector per bit offset
  for (genvar p = 0; p < WIN_W; p++) begin : gDetect
    pvd_len_detect #(
      .MAX_LEN(MAX_LEN),
      .LEN_W(LEN_W),
      .LEN_COUNT(LEN_COUNT)
    ) det_i (
      .look(padded[PAD_W-1-p -: MAX_LEN]),
      .len(posLen[p]),
      .offset(posOff[p])
    );
    assign posFit[p] = (posLen[p] != '0) && ((p + int'(posLen[p])) <= WIN_W);
  end

  // Chained selection: walk from offset 0, jumping by each accepted length
  always_comb begin : chainSel
    logic [POS_W-1:0] cur;
    logic live;
    logic fit;
    logic [LEN_W-1:0] l;
    logic [MAX_LEN-1:0] o;
    cur = '0;
    live = 1'b1;
    nextCnt = '0;
    for (int s = 0; s < SLOTS; s++) begin
      l = '0;
      o = '0;
      fit = 1'b0;
      for (int p = 0; p < WIN_W; p++) begin
        if (cur == POS_W'(p)) begin
          l = posLen[p];
          o = posOff[p];
          fit = posFit[p];
        end
      end
      live = live && fit;
      nextValid[s] = live;
      nextIdx[s] = live ? {l, o} : '0;
      if (live) begin
        cur = cur + POS_W'(l);
        nextCnt = nextCnt + CNT_W'(1);
      end
    end
    nextUsed = cur;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      symIdxQ <= '0;
      symValidQ <= '0;
      symCountQ <= '0;
      usedBitsQ <= '0;
    end else if (strobe.loadEn) begin
      symIdxQ <= nextIdx;
      symValidQ <= nextValid;
      symCountQ <= nextCnt;
      usedBitsQ <= nextUsed;
    end
  end

  // R7
  contig_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((symValidQ & (symValidQ + 1'b1)) == '0));

  // R7
  count_match_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($countones(symValidQ) == int'(symCountQ)));

  // R4
  used_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    (int'(usedBitsQ) <= WIN_W));

endmodule

// File: rtl/pvd_decoder.sv
module pvd_decoder #(
  parameter int WIN_W = 32,
  parameter int MAX_LEN = 8,
  parameter int SLOTS = 8,
  parameter int unsigned LEN_COUNT [MAX_LEN] = pvd_pkg::DEF_LEN_COUNT,
  localparam int LEN_W = $clog2(MAX_LEN + 1),
  localparam int POS_W = $clog2(WIN_W + 1),
  localparam int CNT_W = $clog2(SLOTS + 1),
  localparam int IDX_W = LEN_W + MAX_LEN
) (
  input  logic clk,
  input  logic rstN,
  input  logic inValid,
  output logic inReady,
  input  logic [WIN_W-1:0] window,
  output logic outValid,
  input  logic outReady,
  output logic [SLOTS*IDX_W-1:0] symIdx,
  output logic [SLOTS-1:0] symValid,
  output logic [CNT_W-1:0] symCount,
  output logic [POS_W-1:0] usedBits
);

  pvd_pkg::pvdStrobe_t strobe;
  logic [SLOTS-1:0][IDX_W-1:0] idxArr;

  pvd_ctrl ctrl_i (
    .clk(clk),
    .rstN(rstN),
    .inValid(inValid),
    .outReady(outReady),
    .inReady(inReady),
    .outValid(outValid),
    .strobe(strobe)
  );

  pvd_datapath #(
    .WIN_W(WIN_W),
    .MAX_LEN(MAX_LEN),
    .SLOTS(SLOTS),
    .LEN_W(LEN_W),
    .POS_W(POS_W),
    .CNT_W(CNT_W),
    .IDX_W(IDX_W),
    .LEN_COUNT(LEN_COUNT)
  ) dp_i (
    .clk(clk),
    .rstN(rstN),
    .window(window),
    .strobe(strobe),
    .symIdxQ(idxArr),
    .symValidQ(symValid),
    .symCountQ(symCount),
    .usedBitsQ(usedBits)
  );

  assign symIdx = idxArr;

  // R9
  hold_data_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> ($stable(symIdx) && $stable(usedBits) && $stable(symCount)));

endmodule

// File: tb/pvd_decoder_tb_top.sv
`timescale 1ns/1ps
module pvd_decoder_tb_top;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic inReady;
  logic [31:0] window = '0;
  logic outValid;
  logic outReady = 1'b1;
  logic [95:0] symIdx;
  logic [7:0] symValid;
  logic [3:0] symCount;
  logic [5:0] usedBits;

  int checks = 0;
  int errors = 0;

  int FC [1:8] = '{0, 0, 2, 8, 22, 52, 116, 248};
  int CN [1:8] = '{0, 1, 2, 3, 4, 6, 8, 8};

  int expIdx [8];
  int expCnt;
  int expUsed;

  logic streamBits [0:1023];
  int encIdx [0:511];
  int decList [0:1023];

  always #10 clk = ~clk;

  pvd_decoder dut_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .window(window), .outValid(outValid), .outReady(outReady),
    .symIdx(symIdx), .symValid(symValid), .symCount(symCount), .usedBits(usedBits)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Serial reference decoder, one codeword at a time
  function automatic void refDecode(input logic [31:0] w);
    int pos = 0;
    bit done = 0;
    expCnt = 0;
    for (int s = 0; s < 8; s++) expIdx[s] = 0;
    for (int s = 0; s < 8; s++) begin
      bit found = 0;
      if (!done) begin
        for (int L = 1; L <= 8; L++) begin
          if (!found && pos + L <= 32) begin
            int v = 0;
            for (int i = 0; i < L; i++) v = (v << 1) | int'(w[31-pos-i]);
            if (v >= FC[L] && v < FC[L] + CN[L]) begin
              found = 1;
              expIdx[s] = L * 256 + (v - FC[L]);
              pos += L;
              expCnt++;
            end
          end
        end
        if (!found) done = 1;
      end
    end
    expUsed = pos;
  endfunction

  task automatic checkAll(input string req);
    chk({req, " outValid"}, int'(outValid), 1);
    chk({req, " count R7"}, int'(symCount), expCnt);
    chk({req, " used R6"}, int'(usedBits), expUsed);
    for (int s = 0; s < 8; s++) begin
      chk({req, " idx R2"}, int'(symIdx[s*12 +: 12]), expIdx[s]);
      chk({req, " valid R7"}, int'(symValid[s]), (s < expCnt) ? 1 : 0);
    end
  endtask

  task automatic decodeOne(input logic [31:0] w);
    @(negedge clk);
    window = w;
    inValid = 1'b1;
    outReady = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 outValid", int'(outValid), 0);
    chk("R1 inReady", int'(inReady), 1);
    chk("R1 symValid", int'(symValid), 0);
    chk("R1 symCount", int'(symCount), 0);
    chk("R1 usedBits", int'(usedBits), 0);
  endtask

  task automatic t_slotLimit();
    decodeOne(32'h0);
    expCnt = 8;
    expUsed = 16;
    for (int s = 0; s < 8; s++) expIdx[s] = 'h200;
    checkAll("R5 slot cap");
  endtask

  task automatic t_longCodes();
    decodeOne({8'd248, 8'd249, 8'd250, 8'd251});
    expCnt = 4;
    expUsed = 32;
    for (int s = 0; s < 8; s++) expIdx[s] = (s < 4) ? ('h800 + s) : 0;
    checkAll("R6 full window");
  endtask

  task automatic t_tail();
    decodeOne({7'd116, 7'd117, 7'd118, 7'd119, 4'hF});
    expCnt = 4;
    expUsed = 28;
    for (int s = 0; s < 8; s++) expIdx[s] = (s < 4) ? ('h700 + s) : 0;
    checkAll("R4 straddle");
  endtask

  task automatic t_random();
    for (int n = 0; n < 40; n++) begin
      logic [31:0] w = $urandom();
      decodeOne(w);
      refDecode(w);
      checkAll("R3 random");
    end
  endtask

  task automatic t_backpressure();
    logic [31:0] wa = {3'd2, 4'd9, 5'd23, 6'd53, 7'd117, 7'd0};
    logic [31:0] wb = 32'hA5C3_1E77;
    @(negedge clk);
    window = wa;
    inValid = 1'b1;
    outReady = 1'b0;
    @(negedge clk);
    window = wb;
    refDecode(wa);
    for (int c = 0; c < 3; c++) begin
      checkAll("R9 stalled");
      chk("R9 inReady", int'(inReady), 0);
      @(negedge clk);
    end
    outReady = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    refDecode(wb);
    checkAll("R9 resume");
  endtask

  task automatic t_stream();
    int encLen = 0;
    int nEnc = 0;
    int nDec = 0;
    int pos = 0;
    bit pend = 0;
    for (int i = 0; i < 1024; i++) streamBits[i] = 1'b0;
    while (encLen < 600) begin
      int L = 2 + int'($urandom() % 7);
      int o = int'($urandom() % CN[L]);
      int code = FC[L] + o;
      for (int i = 0; i < L; i++) streamBits[encLen+i] = code[L-1-i];
      encIdx[nEnc] = L * 256 + o;
      nEnc++;
      encLen += L;
    end
    outReady = 1'b1;
    while (pos < encLen) begin
      logic [31:0] w;
      @(negedge clk);
      if (pend) begin
        checkAll("R8 streaming");
        for (int s = 0; s < int'(symCount); s++) begin
          decList[nDec] = int'(symIdx[s*12 +: 12]);
          nDec++;
        end
      end
      for (int i = 0; i < 32; i++) w[31-i] = (pos + i < 1024) ? streamBits[pos+i] : 1'b0;
      window = w;
      inValid = 1'b1;
      refDecode(w);
      pend = 1;
      pos += expUsed;
    end
    @(negedge clk);
    inValid = 1'b0;
    checkAll("R8 streaming");
    for (int s = 0; s < int'(symCount); s++) begin
      decList[nDec] = int'(symIdx[s*12 +: 12]);
      nDec++;
    end
    chk("R3 stream length", (nDec >= nEnc) ? 1 : 0, 1);
    for (int i = 0; i < nEnc; i++) chk("R2 stream symbol", decList[i], encIdx[i]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rstN = 1'b1;
    t_slotLimit();
    t_longCodes();
    t_tail();
    t_random();
    t_backpressure();
    t_stream();
    repeat (2) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule